// File: doc/BRIEF.md
# Processor Sleep Entry and Wake Controller

This block sits on the core side of a processor and sequences its deepest power-saving mode. Software first picks sleep as the low-power mode through a configuration bit, then requests power-down by setting a power-enable bit. The controller then moves through a fixed sequence. It waits until no bus operation is outstanding. It raises a quiesce request to system logic, meaning the core is ready to stop snooping. It waits for the system's quiesce acknowledge, counts a fixed number of clocks, and finally turns off the clock enables of the functional units, the time base and the snoop logic.

Any of four wake inputs brings the core back to full power. These are an external interrupt, a system management interrupt, a machine check and a soft reset. The wake takes one cycle of withdrawal and then one of restore, and the power-enable bit is cleared so that the core does not fall straight back asleep. A wake that arrives while the core is still draining or waiting for the acknowledge cancels the request. An asynchronous hard reset returns everything to the reset state at any time. A 2-bit status code reports the current phase.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: Entry starts only when the sleep-select input is 1 and the power-enable bit is 1. The status code becomes 01 on the clock edge after the bit is set. With sleep-select at 0, a set power-enable bit leaves the block at status 00.
- R2: The power-enable bit takes `pwr_wdata` on a `pwr_wr` strobe only while the status is 00. Strobes given in any other phase leave `pwr_en_bit` unchanged.
- R3: During entry, `quiesce_req` stays low as long as `bus_pending` is non-zero. It rises on the edge after a zero count is sampled.
- R4: While `quiesce_req` is high and `quiesce_ack` is low, the block holds with `quiesce_req` high and the status at 01, for any number of cycles.
- R5: `snoop_en` falls on the edge that samples `quiesce_ack` high. The status becomes 10 exactly ENTRY_DLY clock edges later.
- R6: While the status is 10, `unit_clk_en`, `tbase_en` and `snoop_en` are all 0 and `quiesce_req` is 1.
- R7: In sleep, a high level on any of `wake_int`, `wake_smi`, `wake_mchk` or `soft_rst` moves the block to status 11 on the next edge. In that phase `quiesce_req` is 0, the enables are still 0 and `pwr_en_bit` is 0. The edge after that gives status 00 with all enables at 1.
- R8: A wake input seen while the block is draining or waiting for acknowledge aborts entry. On the next edge the status is 00, `quiesce_req` is 0 and `pwr_en_bit` is 0.
- R9: Once the acknowledge has been sampled, wake inputs do not shorten the countdown. Sleep is still reached after ENTRY_DLY edges, and a held wake input then leads to status 11.
- R10: Asserting `hard_rst_n` low returns the block at once to the reset state: status 00, `quiesce_req` 0, all enables 1 and `pwr_en_bit` 0. This holds from any phase, sleep included.
- R11: The status codes are 00 for full power, 01 for entering (draining, waiting for acknowledge, counting down), 10 for sleep and 11 for waking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| hard_rst_n | input | 1 | Asynchronous hard reset, active low |
| sleep_sel | input | 1 | Configuration bit selecting sleep as the low-power mode |
| pwr_wr | input | 1 | Write strobe for the power-enable bit |
| pwr_wdata | input | 1 | Value written to the power-enable bit |
| bus_pending | input | CNT_W | Number of outstanding bus operations |
| quiesce_req | output | 1 | Quiesce request to system logic |
| quiesce_ack | input | 1 | Quiesce acknowledge from system logic |
| wake_int | input | 1 | External interrupt wake source |
| wake_smi | input | 1 | System management interrupt wake source |
| wake_mchk | input | 1 | Machine check wake source |
| soft_rst | input | 1 | Soft reset wake source |
| unit_clk_en | output | 1 | Clock enable for functional units |
| tbase_en | output | 1 | Clock enable for time base and decrementer |
| snoop_en | output | 1 | Bus snoop enable |
| pwr_en_bit | output | 1 | Current power-enable bit |
| mode_code | output | 2 | Current phase code |

## Verification
The bench builds the controller with ENTRY_DLY set to 3 and a 4-bit pending count. The short delay lets every edge of the countdown be checked one at a time, in the same run as the earlier and later phases. The narrow count lets the drain hold be driven from a mid-range value down to zero. With these settings each of the four wake sources gets its own full sleep cycle. Aborts in each of the two early phases, a wake held through the countdown, and a hard reset in the middle of sleep also fit easily within the run.

// File: rtl/pwr_sleep_pkg.sv
package pwr_sleep_pkg;

    typedef enum logic [2:0] {
        ST_RUN     = 3'd0,
        ST_DRAIN   = 3'd1,
        ST_QWAIT   = 3'd2,
        ST_DELAY   = 3'd3,
        ST_SLEEP   = 3'd4,
        ST_WAKE    = 3'd5
    } pwr_state_e;

    localparam logic [1:0] MC_FULL  = 2'b00;
    localparam logic [1:0] MC_ENTER = 2'b01;
    localparam logic [1:0] MC_SLEEP = 2'b10;
    localparam logic [1:0] MC_WAKE  = 2'b11;

    localparam int unsigned N_WAKE_SRC = 4;

endpackage

// File: rtl/pwr_wake_sense.sv
module pwr_wake_sense #(
    parameter int unsigned N_SRC = 4
) (
    input  logic [N_SRC-1:0] src_i,
    output logic             any_o
);
    logic [N_SRC:0] chain;

    assign chain[0] = 1'b0;
    for (genvar g = 0; g < N_SRC; g++) begin : g_or
        assign chain[g+1] = chain[g] | src_i[g];
    end
    assign any_o = chain[N_SRC];

endmodule

// File: rtl/pwr_entry_timer.sv
module pwr_entry_timer #(
    parameter int unsigned ENTRY_DLY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic run_i,
    output logic done_o
);
    localparam int unsigned DW = (ENTRY_DLY < 2) ? 1 : $clog2(ENTRY_DLY);
    localparam logic [DW-1:0] LAST = DW'(ENTRY_DLY - 1);

    logic [DW-1:0] cnt_d, cnt_q;

    assign done_o = run_i && (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = '0;
        else if (run_i && !done_o)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl
    import pwr_sleep_pkg::*;
#(
    parameter int unsigned CNT_W     = 4,
    parameter int unsigned ENTRY_DLY = 4
) (
    input  logic             clk,
    input  logic             hard_rst_n,
    input  logic             sleep_sel,
    input  logic             pwr_wr,
    input  logic             pwr_wdata,
    input  logic [CNT_W-1:0] bus_pending,
    output logic             quiesce_req,
    input  logic             quiesce_ack,
    input  logic             wake_int,
    input  logic             wake_smi,
    input  logic             wake_mchk,
    input  logic             soft_rst,
    output logic             unit_clk_en,
    output logic             tbase_en,
    output logic             snoop_en,
    output logic             pwr_en_bit,
    output logic [1:0]       mode_code
);

    typedef struct packed {
        pwr_state_e st;
        logic       pow;
    } ctrl_t;

    ctrl_t r_d, r_q;
    logic  wake_any;
    logic  tmr_load, tmr_run, tmr_done;

    pwr_wake_sense #(.N_SRC(N_WAKE_SRC)) i_wake (
        .src_i ({soft_rst, wake_mchk, wake_smi, wake_int}),
        .any_o (wake_any)
    );

    assign tmr_load = (r_q.st == ST_QWAIT) && quiesce_ack;
    assign tmr_run  = (r_q.st == ST_DELAY);

    pwr_entry_timer #(.ENTRY_DLY(ENTRY_DLY)) i_tmr (
        .clk    (clk),
        .rst_n  (hard_rst_n),
        .load_i (tmr_load),
        .run_i  (tmr_run),
        .done_o (tmr_done)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_RUN: begin
                if (pwr_wr)
                    r_d.pow = pwr_wdata;
                if (r_q.pow && sleep_sel)
                    r_d.st = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (wake_any) begin
                    r_d.st  = ST_RUN;
                    r_d.pow = 1'b0;
                end else if (bus_pending == '0) begin
                    r_d.st = ST_QWAIT;
                end
            end
            ST_QWAIT: begin
                if (wake_any) begin
                    r_d.st  = ST_RUN;
                    r_d.pow = 1'b0;
                end else if (quiesce_ack) begin
                    r_d.st = ST_DELAY;
                end
            end
            ST_DELAY: begin
                if (tmr_done)
                    r_d.st = ST_SLEEP;
            end
            ST_SLEEP: begin
                if (wake_any) begin
                    r_d.st  = ST_WAKE;
                    r_d.pow = 1'b0;
                end
            end
            ST_WAKE: r_d.st = ST_RUN;
            default: r_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge hard_rst_n) begin
        if (!hard_rst_n) begin
            r_q.st  <= ST_RUN;
            r_q.pow <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        quiesce_req = 1'b0;
        unit_clk_en = 1'b1;
        tbase_en    = 1'b1;
        snoop_en    = 1'b1;
        mode_code   = MC_FULL;
        unique case (r_q.st)
            ST_RUN:   ;
            ST_DRAIN: mode_code = MC_ENTER;
            ST_QWAIT: begin
                mode_code   = MC_ENTER;
                quiesce_req = 1'b1;
            end
            ST_DELAY: begin
                mode_code   = MC_ENTER;
                quiesce_req = 1'b1;
                snoop_en    = 1'b0;
            end
            ST_SLEEP: begin
                mode_code   = MC_SLEEP;
                quiesce_req = 1'b1;
                snoop_en    = 1'b0;
                unit_clk_en = 1'b0;
                tbase_en    = 1'b0;
            end
            ST_WAKE: begin
                mode_code   = MC_WAKE;
                snoop_en    = 1'b0;
                unit_clk_en = 1'b0;
                tbase_en    = 1'b0;
            end
            default: ;
        endcase
    end

    assign pwr_en_bit = r_q.pow;

    // R3
    req_after_drain_chk: assert property (@(posedge clk) disable iff (!hard_rst_n)
        $rose(quiesce_req) |-> $past(bus_pending) == '0);

    // R6
    sleep_gated_chk: assert property (@(posedge clk) disable iff (!hard_rst_n)
        (mode_code == MC_SLEEP) |-> (!unit_clk_en && !tbase_en && !snoop_en && quiesce_req));

    // R7
    sleep_wake_chk: assert property (@(posedge clk) disable iff (!hard_rst_n)
        (mode_code == MC_SLEEP && (wake_int || wake_smi || wake_mchk || soft_rst))
        |=> (mode_code == MC_WAKE && !quiesce_req && !pwr_en_bit));

    // R7
    wake_restore_chk: assert property (@(posedge clk) disable iff (!hard_rst_n)
        (mode_code == MC_WAKE) |=> (mode_code == MC_FULL && unit_clk_en && tbase_en && snoop_en));

    // R4
    ack_hold_chk: assert property (@(posedge clk) disable iff (!hard_rst_n)
        (r_q.st == ST_QWAIT && !quiesce_ack && !wake_int && !wake_smi && !wake_mchk && !soft_rst)
        |=> quiesce_req && mode_code == MC_ENTER);

    // R8
    req_drop_chk: assert property (@(posedge clk) disable iff (!hard_rst_n)
        $fell(quiesce_req) |-> (mode_code == MC_FULL || mode_code == MC_WAKE));

endmodule

// File: tb/test_pwr_sleep_ctrl.sv
module test_pwr_sleep_ctrl;

    localparam int unsigned CNT_W = 4;
    localparam int unsigned DLY   = 3;

    logic clk = 1'b0;
    logic hard_rst_n = 1'b0;
    logic sleep_sel = 1'b0, pwr_wr = 1'b0, pwr_wdata = 1'b0;
    logic [CNT_W-1:0] bus_pending = '0;
    logic quiesce_ack = 1'b0;
    logic wake_int = 1'b0, wake_smi = 1'b0, wake_mchk = 1'b0, soft_rst = 1'b0;
    logic quiesce_req, unit_clk_en, tbase_en, snoop_en, pwr_en_bit;
    logic [1:0] mode_code;

    int n_run = 0, n_fail = 0;

    always #5 clk = ~clk;

    pwr_sleep_ctrl #(.CNT_W(CNT_W), .ENTRY_DLY(DLY)) i_pwr_sleep_ctrl (
        .clk(clk), .hard_rst_n(hard_rst_n), .sleep_sel(sleep_sel),
        .pwr_wr(pwr_wr), .pwr_wdata(pwr_wdata), .bus_pending(bus_pending),
        .quiesce_req(quiesce_req), .quiesce_ack(quiesce_ack),
        .wake_int(wake_int), .wake_smi(wake_smi), .wake_mchk(wake_mchk),
        .soft_rst(soft_rst), .unit_clk_en(unit_clk_en), .tbase_en(tbase_en),
        .snoop_en(snoop_en), .pwr_en_bit(pwr_en_bit), .mode_code(mode_code)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Advance one edge; inputs and samples settle 1 ns after the edge.
    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    // outputs packed as {mode,qreq,unit,tbase,snoop,pow}
    function automatic int outs();
        return {mode_code, quiesce_req, unit_clk_en, tbase_en, snoop_en, pwr_en_bit};
    endfunction

    function automatic int pk(input int m, q, u, t, s, p);
        return (m << 5) | (q << 4) | (u << 3) | (t << 2) | (s << 1) | p;
    endfunction

    task automatic write_pow(input logic v);
        pwr_wr = 1'b1; pwr_wdata = v;
        tick();
        pwr_wr = 1'b0; pwr_wdata = 1'b0;
    endtask

    // Bring the block into sleep from full power; ack held high.
    task automatic go_sleep();
        sleep_sel = 1'b1; bus_pending = '0;
        write_pow(1'b1);
        tick();            // DRAIN
        tick();            // QWAIT
        quiesce_ack = 1'b1;
        tick(DLY + 1);     // DELAY then SLEEP
    endtask

    task automatic t_reset();
        chk("R10 reset outputs", outs(), pk(0, 0, 1, 1, 1, 0));
        chk("R11 reset code", mode_code, 0);
    endtask

    task automatic t_no_select();
        sleep_sel = 1'b0;
        write_pow(1'b1);
        tick(3);
        chk("R1 pow without select stays full", mode_code, 0);
        chk("R2 pow writable in full power", pwr_en_bit, 1);
        write_pow(1'b0);
        chk("R2 pow cleared by write", pwr_en_bit, 0);
    endtask

    task automatic t_full_entry();
        sleep_sel = 1'b1; bus_pending = 4'd6;
        write_pow(1'b1);
        chk("R1 still full on edge that sets pow", mode_code, 0);
        tick();
        chk("R1 entry begins", mode_code, 1);
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R3 no req while pending", quiesce_req, 0);
            bus_pending = bus_pending - 4'd2;
        end
        tick();
        chk("R3 req after drain", outs(), pk(1, 1, 1, 1, 1, 1));
        tick(5);
        chk("R4 hold without ack", outs(), pk(1, 1, 1, 1, 1, 1));
        quiesce_ack = 1'b1;
        tick();
        chk("R5 snoop off after ack", outs(), pk(1, 1, 1, 1, 0, 1));
        tick(DLY - 1);
        chk("R5 still entering one edge early", mode_code, 1);
        pwr_wr = 1'b1; pwr_wdata = 1'b0;
        tick();
        pwr_wr = 1'b0;
        chk("R6 sleep outputs", outs(), pk(2, 1, 0, 0, 0, 1));
        chk("R2 write during entry ignored", pwr_en_bit, 1);
        tick(4);
        chk("R6 sleep holds", outs(), pk(2, 1, 0, 0, 0, 1));
        wake_int = 1'b1;
        tick();
        wake_int = 1'b0; quiesce_ack = 1'b0;
        chk("R7 waking via int", outs(), pk(3, 0, 0, 0, 0, 0));
        tick();
        chk("R7 full power restored", outs(), pk(0, 0, 1, 1, 1, 0));
        tick(2);
        chk("R7 no re-entry", mode_code, 0);
    endtask

    task automatic t_wake_sources();
        for (int s = 1; s < 4; s++) begin
            go_sleep();
            chk("R6 asleep before wake source", mode_code, 2);
            case (s)
                1: wake_smi = 1'b1;
                2: wake_mchk = 1'b1;
                default: soft_rst = 1'b1;
            endcase
            tick();
            wake_smi = 1'b0; wake_mchk = 1'b0; soft_rst = 1'b0; quiesce_ack = 1'b0;
            chk($sformatf("R7 wake source %0d", s), outs(), pk(3, 0, 0, 0, 0, 0));
            tick();
            chk($sformatf("R7 restore source %0d", s), outs(), pk(0, 0, 1, 1, 1, 0));
        end
    endtask

    task automatic t_aborts();
        sleep_sel = 1'b1; bus_pending = 4'd3;
        write_pow(1'b1);
        tick();
        chk("R8 in drain", mode_code, 1);
        wake_smi = 1'b1;
        tick();
        wake_smi = 1'b0;
        chk("R8 abort from drain", outs(), pk(0, 0, 1, 1, 1, 0));
        bus_pending = '0;
        write_pow(1'b1);
        tick(2);
        chk("R8 in ack wait", quiesce_req, 1);
        wake_mchk = 1'b1;
        tick();
        wake_mchk = 1'b0;
        chk("R8 abort from ack wait", outs(), pk(0, 0, 1, 1, 1, 0));
    endtask

    task automatic t_wake_in_delay();
        sleep_sel = 1'b1; bus_pending = '0;
        write_pow(1'b1);
        tick(2);
        quiesce_ack = 1'b1;
        tick();
        wake_int = 1'b1;
        tick(DLY - 1);
        chk("R9 countdown not cut", mode_code, 1);
        tick();
        chk("R9 sleep reached", mode_code, 2);
        tick();
        wake_int = 1'b0; quiesce_ack = 1'b0;
        chk("R9 held wake then wakes", mode_code, 3);
        tick();
    endtask

    task automatic t_hard_reset();
        go_sleep();
        chk("R10 asleep before reset", mode_code, 2);
        #2 hard_rst_n = 1'b0;
        #1;
        chk("R10 async reset in sleep", outs(), pk(0, 0, 1, 1, 1, 0));
        quiesce_ack = 1'b0;
        tick();
        hard_rst_n = 1'b1;
        tick(2);
        chk("R10 stays full after reset", mode_code, 0);
    endtask

    initial begin
        #200000;
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        tick(2);
        t_reset();
        hard_rst_n = 1'b1;
        tick();
        t_no_select();
        t_full_entry();
        t_wake_sources();
        t_aborts();
        t_wake_in_delay();
        t_hard_reset();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule